// File: doc/BRIEF.md
# Unconditional Debug Request Responder

This block sits between a JTAG-side debug tool and a processor core. When the tool raises its unconditional debug request, the block decides how the core responds. The choice depends on which debug modes are active and on the core's debug-interrupt enable bit. The request has no enable of its own, so it is always recognised.

The block can respond in four ways:
- Stop the core and hold the address of the instruction that would have run next.
- Raise a debug interrupt and load that address into a critical save register.
- Record the event as imprecise and raise the interrupt later, once software turns the enable on.
- Pulse a trace indication and let execution continue.

A two-bit write-one-to-clear status register records what happened. The core appears only as a next-PC input, an interrupt-acknowledge input and the halt and interrupt outputs.

Top module: `dbg_evt_resp_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge and the status register reads 00.
- R2: The request is recognised on the first rising edge where `dbg_req_i` is 1 after being 0 at the previous edge. A request held high for many cycles counts once. Every recognised request sets status bit 0 (event) at that same edge, in every mode.
- R3: If external-debug or wait mode is on, a recognised request makes `halt_o` 1 at that edge and loads `halt_pc_o` with `next_pc_i` sampled there. This stop response takes precedence over internal mode.
- R4: `halt_o` stays 1 and `halt_pc_o` stays unchanged until `resume_i` is sampled high. At that edge `halt_o` drops and `resume_o` is 1 for exactly one cycle, with `halt_pc_o` giving the restart address. `resume_i` while not halted has no effect.
- R5: With internal mode on, no stop mode on, and `dbg_irq_en_i`=1, a recognised request sets `irq_req_o` and loads `save_addr_o` with `next_pc_i`. Both hold until `irq_ack_i` is sampled high, and `irq_req_o` drops at that edge.
- R6: With internal mode on, no stop mode on, and `dbg_irq_en_i`=0, a recognised request sets status bits 0 and 1 (bit 1 = imprecise). It raises neither `irq_req_o` nor `halt_o`.
- R7: A deferred request raises `irq_req_o` at the first later edge where all of the following hold:
  - `dbg_irq_en_i` is 1;
  - status bit 0 is still set and is not being cleared;
  - no halt or interrupt is outstanding;
  - no new request is recognised.

  At that edge `save_addr_o` loads `next_pc_i`.
- R8: A write with `sts_clr_we_i`=1 clears each status bit whose `sts_clr_i` bit is 1. Clearing bit 0 cancels a deferred interrupt. A request recognised in the same cycle sets its bits anyway.
- R9: A request recognised while `halt_o` or `irq_req_o` is 1 only sets status bit 0. It does not reload `halt_pc_o` or `save_addr_o` and starts no second response.
- R10: With trace mode on, every recognised request gives a one-cycle pulse on `trace_evt_o` at the recognising edge. Trace mode alone neither halts nor interrupts.
- R11: With no mode on, a recognised request only sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_req_i | input | 1 | Unconditional request from the debug tool (level; edge-detected) |
| resume_i | input | 1 | Debug tool resume command |
| mode_ext_i | input | 1 | External debug mode active |
| mode_wait_i | input | 1 | Debug wait mode active |
| mode_int_i | input | 1 | Internal debug mode active |
| mode_trace_i | input | 1 | Trace mode active |
| dbg_irq_en_i | input | 1 | Core debug-interrupt enable |
| next_pc_i | input | PC_W | Address of the instruction the core would execute next |
| irq_ack_i | input | 1 | Core has taken the debug interrupt |
| sts_clr_we_i | input | 1 | Status clear write strobe |
| sts_clr_i | input | 2 | Write-one-to-clear mask (bit 0 event, bit 1 imprecise) |
| halt_o | output | 1 | Core stopped |
| halt_pc_o | output | PC_W | Latched restart address |
| resume_o | output | 1 | One-cycle restart strobe |
| irq_req_o | output | 1 | Debug interrupt request to the core |
| save_addr_o | output | PC_W | Critical save register contents |
| sts_o | output | 2 | Status: bit 0 event, bit 1 imprecise |
| trace_evt_o | output | 1 | Trace interface event pulse |

## Verification
Every result of this block is registered once. Halt, interrupt, status, trace pulse and captured addresses all change at the rising edge that first samples the causing request, resume, acknowledge, clear or enable. The resume strobe lasts exactly the cycle after that edge. The bench drives inputs 1 ns after a rising edge and compares all outputs 1 ns after the next rising edge. Its behavioural model is updated at that same edge, so each expected value is due in the cycle it is compared. The deferred path is covered for firing, for cancellation by a clear, and for a clear and a request arriving in the same cycle.

// File: rtl/dbgresp_pkg.sv
package dbgresp_pkg;

    localparam int STS_W   = 2;
    localparam int EVT_BIT = 0;
    localparam int IMP_BIT = 1;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_STOP  = 2'd1,
        ACT_INTR  = 2'd2,
        ACT_DEFER = 2'd3
    } act_e;

    typedef struct packed {
        logic ext_dbg;
        logic wait_dbg;
        logic int_dbg;
        logic trace_dbg;
    } mode_t;

    // Response to a recognised request; stop modes outrank internal mode.
    function automatic act_e pick_action(mode_t m, logic irq_en, logic busy);
        if (busy)                    return ACT_NONE;
        if (m.ext_dbg || m.wait_dbg) return ACT_STOP;
        if (m.int_dbg && irq_en)     return ACT_INTR;
        if (m.int_dbg)               return ACT_DEFER;
        return ACT_NONE;
    endfunction

endpackage

// File: rtl/dbgresp_edge_det.sv
module dbgresp_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/dbgresp_status.sv
module dbgresp_status
    import dbgresp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_evt_i,
    input  logic             set_imp_i,
    input  logic             clr_we_i,
    input  logic [STS_W-1:0] clr_mask_i,
    input  logic             arm_i,
    input  logic             fire_i,
    output logic [STS_W-1:0] sts_o,
    output logic             pend_o
);
    logic [STS_W-1:0] set_v;

    always_comb begin
        set_v          = '0;
        set_v[EVT_BIT] = set_evt_i;
        set_v[IMP_BIT] = set_imp_i;
    end

    for (genvar b = 0; b < STS_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                            sts_o[b] <= 1'b0;
            else if (set_v[b])                  sts_o[b] <= 1'b1;
            else if (clr_we_i && clr_mask_i[b]) sts_o[b] <= 1'b0;
        end
    end

    // Deferred interrupt marker; new arming wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (rst)                                      pend_o <= 1'b0;
        else if (arm_i)                               pend_o <= 1'b1;
        else if (clr_we_i && clr_mask_i[EVT_BIT])     pend_o <= 1'b0;
        else if (fire_i)                              pend_o <= 1'b0;
    end
endmodule

// File: rtl/dbgresp_core_ctrl.sv
module dbgresp_core_ctrl
    import dbgresp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  act_e            act_i,
    input  logic            fire_i,
    input  logic            trace_hit_i,
    input  logic            resume_i,
    input  logic            ack_i,
    input  logic [PC_W-1:0] pc_i,
    output logic            halt_o,
    output logic [PC_W-1:0] halt_pc_o,
    output logic            resume_o,
    output logic            irq_o,
    output logic [PC_W-1:0] save_o,
    output logic            trace_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_o    <= 1'b0;
            halt_pc_o <= '0;
            resume_o  <= 1'b0;
            irq_o     <= 1'b0;
            save_o    <= '0;
            trace_o   <= 1'b0;
        end else begin
            resume_o <= 1'b0;
            trace_o  <= trace_hit_i;
            if (halt_o && resume_i) begin
                halt_o   <= 1'b0;
                resume_o <= 1'b1;
            end
            if (irq_o && ack_i) irq_o <= 1'b0;
            unique case (act_i)
                ACT_STOP: begin
                    halt_o    <= 1'b1;
                    halt_pc_o <= pc_i;
                end
                ACT_INTR: begin
                    irq_o  <= 1'b1;
                    save_o <= pc_i;
                end
                default: ;
            endcase
            if (fire_i) begin
                irq_o  <= 1'b1;
                save_o <= pc_i;
            end
        end
    end
endmodule

// File: rtl/dbg_evt_resp_ctrl.sv
module dbg_evt_resp_ctrl
    import dbgresp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dbg_req_i,
    input  logic            resume_i,
    input  logic            mode_ext_i,
    input  logic            mode_wait_i,
    input  logic            mode_int_i,
    input  logic            mode_trace_i,
    input  logic            dbg_irq_en_i,
    input  logic [PC_W-1:0] next_pc_i,
    input  logic            irq_ack_i,
    input  logic            sts_clr_we_i,
    input  logic [1:0]      sts_clr_i,
    output logic            halt_o,
    output logic [PC_W-1:0] halt_pc_o,
    output logic            resume_o,
    output logic            irq_req_o,
    output logic [PC_W-1:0] save_addr_o,
    output logic [1:0]      sts_o,
    output logic            trace_evt_o
);
    logic  req_rise;
    logic  busy;
    logic  pend;
    logic  fire;
    logic  clr_evt;
    act_e  act;
    mode_t modes;

    assign modes   = '{ext_dbg: mode_ext_i, wait_dbg: mode_wait_i,
                       int_dbg: mode_int_i, trace_dbg: mode_trace_i};
    assign busy    = halt_o | irq_req_o;
    assign clr_evt = sts_clr_we_i & sts_clr_i[EVT_BIT];
    assign act     = req_rise ? pick_action(modes, dbg_irq_en_i, busy) : ACT_NONE;
    assign fire    = pend & dbg_irq_en_i & sts_o[EVT_BIT] & ~clr_evt & ~busy & ~req_rise;

    dbgresp_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (dbg_req_i),
        .rise_o (req_rise)
    );

    dbgresp_status u_sts (
        .clk        (clk),
        .rst        (rst),
        .set_evt_i  (req_rise),
        .set_imp_i  (act == ACT_DEFER),
        .clr_we_i   (sts_clr_we_i),
        .clr_mask_i (sts_clr_i),
        .arm_i      (act == ACT_DEFER),
        .fire_i     (fire),
        .sts_o      (sts_o),
        .pend_o     (pend)
    );

    dbgresp_core_ctrl #(.PC_W(PC_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .act_i       (act),
        .fire_i      (fire),
        .trace_hit_i (req_rise & modes.trace_dbg),
        .resume_i    (resume_i),
        .ack_i       (irq_ack_i),
        .pc_i        (next_pc_i),
        .halt_o      (halt_o),
        .halt_pc_o   (halt_pc_o),
        .resume_o    (resume_o),
        .irq_o       (irq_req_o),
        .save_o      (save_addr_o),
        .trace_o     (trace_evt_o)
    );
endmodule

// File: rtl/dbg_evt_resp_chk.sv
module dbg_evt_resp_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            dbg_req_i,
    input logic            resume_i,
    input logic            irq_ack_i,
    input logic            halt_o,
    input logic [PC_W-1:0] halt_pc_o,
    input logic            resume_o,
    input logic            irq_req_o,
    input logic [PC_W-1:0] save_addr_o,
    input logic [1:0]      sts_o,
    input logic            trace_evt_o
);
    p_halt_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_o) |-> ($past(dbg_req_i) && sts_o[0]));

    p_halt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (halt_o && !resume_i) |=> (halt_o && $stable(halt_pc_o)));

    p_resume_once_r4: assert property (@(posedge clk) disable iff (rst)
        resume_o |=> !resume_o);

    p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && !irq_ack_i) |=> (irq_req_o && $stable(save_addr_o)));

    p_single_resp_r9: assert property (@(posedge clk) disable iff (rst)
        !(halt_o && irq_req_o));

    p_trace_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        trace_evt_o |=> !trace_evt_o);

    p_trace_cause_r10: assert property (@(posedge clk) disable iff (rst)
        trace_evt_o |-> ($past(dbg_req_i) && sts_o[0]));
endmodule

bind dbg_evt_resp_ctrl dbg_evt_resp_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dbg_req_i   (dbg_req_i),
    .resume_i    (resume_i),
    .irq_ack_i   (irq_ack_i),
    .halt_o      (halt_o),
    .halt_pc_o   (halt_pc_o),
    .resume_o    (resume_o),
    .irq_req_o   (irq_req_o),
    .save_addr_o (save_addr_o),
    .sts_o       (sts_o),
    .trace_evt_o (trace_evt_o)
);

// File: tb/tb_dbg_evt_resp_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_evt_resp_ctrl;
    localparam int PC_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 0, resume = 0, m_ext = 0, m_wait = 0, m_int = 0, m_trc = 0;
    logic en = 0, ack = 0, clr_we = 0;
    logic [1:0] clr = 0;
    logic [PC_W-1:0] pc = '0;

    logic            halt_o, resume_o, irq_o, trace_o;
    logic [PC_W-1:0] hpc_o, save_o;
    logic [1:0]      sts_o;

    always #2.5 clk = ~clk;

    dbg_evt_resp_ctrl #(.PC_W(PC_W)) dut (
        .clk(clk), .rst(rst), .dbg_req_i(req), .resume_i(resume),
        .mode_ext_i(m_ext), .mode_wait_i(m_wait), .mode_int_i(m_int),
        .mode_trace_i(m_trc), .dbg_irq_en_i(en), .next_pc_i(pc),
        .irq_ack_i(ack), .sts_clr_we_i(clr_we), .sts_clr_i(clr),
        .halt_o(halt_o), .halt_pc_o(hpc_o), .resume_o(resume_o),
        .irq_req_o(irq_o), .save_addr_o(save_o), .sts_o(sts_o),
        .trace_evt_o(trace_o)
    );

    // Behavioural reference model
    bit              e_prev, e_halt, e_res, e_irq, e_trc, e_pend;
    bit [1:0]        e_sts;
    logic [PC_W-1:0] e_hpc, e_sav;

    always @(posedge clk) begin
        bit rec, busy, kill, stopm;
        rec   = req && !e_prev;
        busy  = e_halt || e_irq;
        kill  = clr_we && clr[0];
        stopm = m_ext || m_wait;
        if (rst) begin
            e_prev = 0; e_halt = 0; e_res = 0; e_irq = 0; e_trc = 0;
            e_pend = 0; e_sts = 0; e_hpc = '0; e_sav = '0;
        end else begin
            bit fire_now;
            fire_now = e_pend && en && e_sts[0] && !kill && !busy && !rec;
            e_prev = req;
            e_res  = 0;
            e_trc  = rec && m_trc;
            if (e_halt && resume) begin e_halt = 0; e_res = 1; end
            if (e_irq && ack) e_irq = 0;
            if (clr_we) e_sts = e_sts & ~clr;
            if (kill) e_pend = 0;
            if (rec) begin
                e_sts[0] = 1;
                if (!busy) begin
                    if (stopm) begin e_halt = 1; e_hpc = pc; end
                    else if (m_int && en) begin e_irq = 1; e_sav = pc; end
                    else if (m_int) begin e_sts[1] = 1; e_pend = 1; end
                end
            end
            if (fire_now) begin e_irq = 1; e_sav = pc; e_pend = 0; end
        end
    end

    int    n_chk = 0, n_bad = 0;
    string phase = "R1";
    bit    done = 0;

    task automatic chk(string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        chk("halt_o", PC_W'(halt_o), PC_W'(e_halt));
        chk("halt_pc_o", hpc_o, e_hpc);
        chk("resume_o", PC_W'(resume_o), PC_W'(e_res));
        chk("irq_req_o", PC_W'(irq_o), PC_W'(e_irq));
        chk("save_addr_o", save_o, e_sav);
        chk("sts_o", PC_W'(sts_o), PC_W'(e_sts));
        chk("trace_evt_o", PC_W'(trace_o), PC_W'(e_trc));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_req(logic [PC_W-1:0] a, int hold);
        pc = a; req = 1; run(hold); req = 0; run(1);
    endtask

    task automatic wipe();
        clr_we = 1; clr = 2'b11; run(1); clr_we = 0; clr = 0; run(1);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_up();
        end
    end

    initial begin
        phase = "R1 reset"; run(3); rst = 0; #0;
        run(2);

        phase = "R11 no mode";  pulse_req(32'h10, 2); run(2);
        phase = "R8 clear";     wipe();

        phase = "R2 long hold"; m_trc = 1; pulse_req(32'h20, 12); m_trc = 0; wipe();

        phase = "R3 ext stop";  m_ext = 1; m_int = 1; en = 1;
        pulse_req(32'h100, 3); run(3);
        phase = "R9 while halted"; pulse_req(32'h1AC, 1); run(2);
        phase = "R4 resume"; resume = 1; run(1); resume = 0; run(3);
        resume = 1; run(2); resume = 0; run(1);
        m_ext = 0; wipe();

        phase = "R3 wait stop"; m_wait = 1; pulse_req(32'h140, 1); run(2);
        resume = 1; run(1); resume = 0; m_wait = 0; run(1); wipe();

        phase = "R5 interrupt"; m_int = 1; en = 1; pulse_req(32'h200, 2); run(3);
        phase = "R9 while irq"; pulse_req(32'h2F0, 1); run(1);
        phase = "R5 ack"; ack = 1; run(1); ack = 0; run(2); wipe();

        phase = "R6 imprecise"; en = 0; pulse_req(32'h300, 1); run(4);
        phase = "R7 deferred"; pc = 32'h344; en = 1; run(3);
        ack = 1; run(1); ack = 0; run(2);
        phase = "R7 imp stays"; run(1); wipe();

        phase = "R8 cancel"; en = 0; pulse_req(32'h400, 1);
        clr_we = 1; clr = 2'b01; run(1); clr_we = 0; clr = 0;
        en = 1; pc = 32'h480; run(4); wipe();

        phase = "R8 clear races set"; en = 0; pc = 32'h500;
        req = 1; clr_we = 1; clr = 2'b11; run(1); clr_we = 0; clr = 0; req = 0;
        run(2); en = 1; pc = 32'h540; run(2); ack = 1; run(1); ack = 0; run(1); wipe();

        phase = "R10 trace only"; m_int = 0; en = 0; m_trc = 1;
        pulse_req(32'h600, 1); pulse_req(32'h604, 1); run(2);
        phase = "R10 trace+intr"; m_int = 1; en = 1; pulse_req(32'h640, 1);
        ack = 1; run(1); ack = 0; m_trc = 0; m_int = 0; run(2); wipe();

        phase = "R1 reset again"; m_ext = 1; pulse_req(32'h700, 1);
        rst = 1; run(2); rst = 0; m_ext = 0; run(2);

        finish_up();
    end
endmodule